// File: doc/BRIEF.md
# Pixel Selection Chain Loader

This block programs one of three external selection shift chains that pick pixels in a sensor matrix: an analog preamp column chain, a charge injection chain and a digital readout chain. Each chain has its own reset (active low), shift clock, serial data and enable lines, and the loader drives only the chain named by the accepted command. The other two chains are left alone.

A command carries a chain code and a pair of 16-bit masks: columns and rows. The loader pulses the chain reset and then shifts the mask bits in. The clock is derived from the system clock, and each data bit is set up half a shift period before its rising edge. Enable is held low for the whole load and is raised only once the chain is full. A one-cycle done pulse marks the end of the load. A readout command whose masks would select more than one pixel, or no pixel, is refused and flagged.

Top module: `pixel_chain_loader`

## Requirements
- R1: After system reset, busy, done and maskErr are 0, every chain reset line is 1, and every chain clock, data and enable line is 0.
- R2: A command is accepted only when cmdValid is high while idle and the chain code is 0 (preamp), 1 (injection) or 2 (readout). A command presented while busy, or with code 3, has no effect on any chain.
- R3: On acceptance, the selected chain's reset line goes low for RST_CYC cycles. It returns high before the first rising edge of that chain's clock.
- R4: The selected chain receives exactly 16 rising clock edges for preamp and 32 for injection or readout. Each clock phase lasts HALF_DIV system cycles.
- R5: At clock rise k (k = 0 first), the data line carries stream bit k. The stream is col[0]..col[15] followed by row[0]..row[15], so row[15] is last. The data line already holds that value one system cycle before the rise.
- R6: The selected chain's enable line goes low on acceptance, stays low for the whole load, rises together with done, and then stays high.
- R7: done is a single-cycle pulse RST_CYC + 2*HALF_DIV*N + 1 cycles after the acceptance edge, where N is the chain length. busy is high from acceptance until the cycle before done.
- R8: A readout command must have exactly one bit set in the column mask and exactly one bit set in the row mask. Otherwise maskErr is set on the next cycle, no load starts, and the chain is untouched. maskErr clears when a command is next accepted.
- R9: An injection command accepts any number of set bits; column 15 with row 15 places ones at stream bits 15 and 31 only. A preamp command shifts only the 16 column bits and ignores the row mask.
- R10: During a load, the clock, reset and enable lines of the unselected chains do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | System reset, active low |
| cmdValid | input | 1 | Command strobe |
| cmdChain | input | 2 | Chain code: 0 preamp, 1 injection, 2 readout |
| cmdColMask | input | 16 | Column mask, bit c selects column c |
| cmdRowMask | input | 16 | Row mask, bit r selects row r |
| busy | output | 1 | Load in progress |
| done | output | 1 | One-cycle end-of-load pulse |
| maskErr | output | 1 | Readout mask was refused |
| chainRstN | output | 3 | Per-chain reset, active low, indexed by chain code |
| chainClk | output | 3 | Per-chain shift clock |
| chainData | output | 3 | Per-chain serial data |
| chainEn | output | 3 | Per-chain enable |

## Verification
Counting from the edge that accepts a command, the reset line is low for RST_CYC samples. Rises of the shift clock then follow every 2*HALF_DIV cycles, and done with enable appears exactly RST_CYC + 2*HALF_DIV*N + 1 edges later; maskErr is due one edge after a refused command. The bench samples at every falling system edge after acceptance, indexes each sample by its edge count, and checks each output only at the index where the requirement places it. Clock rises are detected by comparing each sample with the previous one, so captured data bits and setup come out of the same samples.

// File: rtl/selchain_pkg.sv
package selchain_pkg;
  localparam int NUM_CH = 3;

  typedef enum logic [1:0] {
    CH_PRE = 2'd0,
    CH_INJ = 2'd1,
    CH_RD  = 2'd2
  } chain_e;

  typedef struct packed {
    logic start;
    logic release_;
    logic rise;
    logic fall;
    logic enable;
  } loadStb_t;

  function automatic logic singleBit(input logic [15:0] m);
    return (m != '0) && ((m & (m - 16'd1)) == '0);
  endfunction
endpackage

// File: rtl/selchain_ctrl.sv
module selchain_ctrl
  import selchain_pkg::*;
#(
  parameter int MASK_W   = 16,
  parameter int RST_CYC  = 2,
  parameter int HALF_DIV = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [1:0]        cmdChain,
  input  logic [MASK_W-1:0] cmdColMask,
  input  logic [MASK_W-1:0] cmdRowMask,
  output loadStb_t          stb,
  output logic              busy,
  output logic              done,
  output logic              maskErr
);
  localparam int SR_W    = 2 * MASK_W;
  localparam int BW      = $clog2(SR_W);
  localparam int CNT_MAX = (RST_CYC > HALF_DIV) ? RST_CYC : HALF_DIV;
  localparam int CW      = $clog2(CNT_MAX + 1);

  typedef enum logic [2:0] {S_IDLE, S_RST, S_LOW, S_HIGH, S_ENA} state_e;

  state_e        st;
  logic [CW-1:0] cnt;
  logic [BW-1:0] bitCnt;
  logic [BW-1:0] lastIdx;
  logic          chainOk, maskOk, errHit;

  assign chainOk = (cmdChain != 2'd3);
  assign maskOk  = (cmdChain != CH_RD) ||
                   (singleBit(16'(cmdColMask)) && singleBit(16'(cmdRowMask)));
  assign errHit  = (st == S_IDLE) && cmdValid && chainOk && !maskOk;

  always_comb begin
    stb          = '0;
    stb.start    = (st == S_IDLE) && cmdValid && chainOk && maskOk;
    stb.release_ = (st == S_RST)  && (cnt == CW'(RST_CYC - 1));
    stb.rise     = (st == S_LOW)  && (cnt == CW'(HALF_DIV - 1));
    stb.fall     = (st == S_HIGH) && (cnt == CW'(HALF_DIV - 1));
    stb.enable   = (st == S_ENA);
  end

  assign busy = (st != S_IDLE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st      <= S_IDLE;
      cnt     <= '0;
      bitCnt  <= '0;
      lastIdx <= '0;
      done    <= 1'b0;
      maskErr <= 1'b0;
    end else begin
      done <= stb.enable;
      if (errHit) maskErr <= 1'b1;
      else if (stb.start) maskErr <= 1'b0;
      case (st)
        S_IDLE: if (stb.start) begin
          st      <= S_RST;
          cnt     <= '0;
          bitCnt  <= '0;
          lastIdx <= (cmdChain == CH_PRE) ? BW'(MASK_W - 1) : BW'(SR_W - 1);
        end
        S_RST: begin
          cnt <= stb.release_ ? '0 : cnt + 1'b1;
          if (stb.release_) st <= S_LOW;
        end
        S_LOW: begin
          cnt <= stb.rise ? '0 : cnt + 1'b1;
          if (stb.rise) st <= S_HIGH;
        end
        S_HIGH: begin
          cnt <= stb.fall ? '0 : cnt + 1'b1;
          if (stb.fall) begin
            if (bitCnt == lastIdx) st <= S_ENA;
            else begin
              bitCnt <= bitCnt + 1'b1;
              st     <= S_LOW;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R7: done lasts exactly one cycle
  a_r7_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  // R7: done follows the end of busy
  a_r7_done_after_busy: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && $past(busy)));
  // R8: a refused command never starts a load
  a_r8_err_no_load: assert property (@(posedge clk) disable iff (!rstN)
    $rose(maskErr) |-> !busy);
  // R2: commands during a load do not restart it
  a_r2_no_restart: assert property (@(posedge clk) disable iff (!rstN)
    (busy && st != S_ENA) |=> busy);
endmodule

// File: rtl/selchain_dpath.sv
module selchain_dpath
  import selchain_pkg::*;
#(
  parameter int MASK_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  loadStb_t          stb,
  input  logic [1:0]        cmdChain,
  input  logic [MASK_W-1:0] cmdColMask,
  input  logic [MASK_W-1:0] cmdRowMask,
  output logic [NUM_CH-1:0] chainRstN,
  output logic [NUM_CH-1:0] chainClk,
  output logic [NUM_CH-1:0] chainData,
  output logic [NUM_CH-1:0] chainEn
);
  localparam int SR_W = 2 * MASK_W;

  logic [SR_W-1:0] shreg;
  logic [1:0]      selR;
  logic            activeR;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shreg   <= '0;
      selR    <= '0;
      activeR <= 1'b0;
    end else begin
      if (stb.start) begin
        selR    <= cmdChain;
        activeR <= 1'b1;
        shreg   <= (cmdChain == CH_PRE) ? {{MASK_W{1'b0}}, cmdColMask}
                                        : {cmdRowMask, cmdColMask};
      end else if (stb.fall) begin
        shreg <= shreg >> 1;
      end
      if (stb.enable) activeR <= 1'b0;
    end
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic rN, ck, dt, en;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        rN <= 1'b1;
        ck <= 1'b0;
        dt <= 1'b0;
        en <= 1'b0;
      end else if (stb.start && cmdChain == 2'(i)) begin
        rN <= 1'b0;
        ck <= 1'b0;
        dt <= 1'b0;
        en <= 1'b0;
      end else if (selR == 2'(i)) begin
        if (stb.release_) begin
          rN <= 1'b1;
          dt <= shreg[0];
        end
        if (stb.rise) ck <= 1'b1;
        if (stb.fall) begin
          ck <= 1'b0;
          dt <= shreg[1];
        end
        if (stb.enable) en <= 1'b1;
      end
    end
    assign chainRstN[i] = rN;
    assign chainClk[i]  = ck;
    assign chainData[i] = dt;
    assign chainEn[i]   = en;
  end

  // R6: enable of the chain being loaded stays low
  a_r6_en_low_loading: assert property (@(posedge clk) disable iff (!rstN)
    activeR |-> !chainEn[selR]);
  // R3: no shift clock while a chain is held in reset
  a_r3_no_clk_in_reset: assert property (@(posedge clk) disable iff (!rstN)
    (chainClk & ~chainRstN) == '0);
  // R5: data is stable across the rising shift edge
  a_r5_setup: assert property (@(posedge clk) disable iff (!rstN)
    (|(chainClk & ~$past(chainClk))) |-> (chainData == $past(chainData)));
  // R10: at most one chain is clocked
  a_r10_one_clk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(chainClk));
endmodule

// File: rtl/pixel_chain_loader.sv
module pixel_chain_loader
  import selchain_pkg::*;
#(
  parameter int MASK_W   = 16,
  parameter int RST_CYC  = 2,
  parameter int HALF_DIV = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [1:0]        cmdChain,
  input  logic [MASK_W-1:0] cmdColMask,
  input  logic [MASK_W-1:0] cmdRowMask,
  output logic              busy,
  output logic              done,
  output logic              maskErr,
  output logic [2:0]        chainRstN,
  output logic [2:0]        chainClk,
  output logic [2:0]        chainData,
  output logic [2:0]        chainEn
);
  loadStb_t stb;

  selchain_ctrl #(.MASK_W(MASK_W), .RST_CYC(RST_CYC), .HALF_DIV(HALF_DIV)) u_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdChain(cmdChain),
    .cmdColMask(cmdColMask), .cmdRowMask(cmdRowMask), .stb(stb),
    .busy(busy), .done(done), .maskErr(maskErr)
  );

  selchain_dpath #(.MASK_W(MASK_W)) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .cmdChain(cmdChain),
    .cmdColMask(cmdColMask), .cmdRowMask(cmdRowMask),
    .chainRstN(chainRstN), .chainClk(chainClk),
    .chainData(chainData), .chainEn(chainEn)
  );
endmodule

// File: tb/sim_pixel_chain_loader.sv
module sim_pixel_chain_loader;
  localparam int RST_CYC  = 2;
  localparam int HALF_DIV = 1;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 1'b0;
  logic [1:0]  cmdChain = '0;
  logic [15:0] cmdColMask = '0, cmdRowMask = '0;
  logic        busy, done, maskErr;
  logic [2:0]  chainRstN, chainClk, chainData, chainEn;

  int errors = 0;
  int checks = 0;

  pixel_chain_loader #(.MASK_W(16), .RST_CYC(RST_CYC), .HALF_DIV(HALF_DIV)) u0 (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdChain(cmdChain),
    .cmdColMask(cmdColMask), .cmdRowMask(cmdRowMask), .busy(busy), .done(done),
    .maskErr(maskErr), .chainRstN(chainRstN), .chainClk(chainClk),
    .chainData(chainData), .chainEn(chainEn)
  );

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic runCmd(input logic [1:0] ch, input logic [15:0] col, input logic [15:0] row,
                        input bit intrude);
    int len = (ch == 2'd0) ? 16 : 32;
    int dueIdx = RST_CYC + 2 * HALF_DIV * len + 1;
    logic [31:0] expv = (ch == 2'd0) ? {16'h0, col} : {row, col};
    logic [31:0] cap = '0;
    int rises = 0;
    bit prevClk = 1'b0;
    bit prevData = 1'b0;
    bit otherBad = 1'b0;
    logic [2:0] enSnap = chainEn;
    @(negedge clk);
    cmdValid = 1'b1; cmdChain = ch; cmdColMask = col; cmdRowMask = row;
    for (int j = 0; j <= dueIdx + 2; j++) begin
      @(negedge clk);
      if (j == 0) cmdValid = 1'b0;
      if (intrude && j == 4) begin
        cmdValid = 1'b1; cmdChain = 2'((ch + 1) % 3);
        cmdColMask = 16'h0001; cmdRowMask = 16'h0001;
      end
      if (intrude && j == 5) cmdValid = 1'b0;
      if (j == 0) begin
        chk(chainRstN[ch] == 1'b0, "R3 reset low at accept", 32'(chainRstN[ch]), 0);
        chk(maskErr == 1'b0, "R8 maskErr cleared on accept", 32'(maskErr), 0);
      end
      if (j == RST_CYC)
        chk(chainRstN[ch] == 1'b1, "R3 reset released", 32'(chainRstN[ch]), 1);
      if (chainClk[ch] && !prevClk) begin
        chk(chainRstN[ch] == 1'b1, "R3 reset high at rise", 32'(chainRstN[ch]), 1);
        chk(chainData[ch] == prevData, "R5 data setup", 32'(chainData[ch]), 32'(prevData));
        if (rises < 32) cap[rises] = chainData[ch];
        rises++;
      end
      prevClk = chainClk[ch];
      prevData = chainData[ch];
      if (j < dueIdx) begin
        chk(busy == 1'b1, "R7 busy during load", 32'(busy), 1);
        chk(done == 1'b0, "R7 done early", 32'(done), 0);
        chk(chainEn[ch] == 1'b0, "R6 enable low during load", 32'(chainEn[ch]), 0);
      end else if (j == dueIdx) begin
        chk(done == 1'b1, "R7 done at due cycle", 32'(done), 1);
        chk(busy == 1'b0, "R7 busy off at done", 32'(busy), 0);
        chk(chainEn[ch] == 1'b1, "R6 enable with done", 32'(chainEn[ch]), 1);
      end else begin
        chk(done == 1'b0, "R7 done single pulse", 32'(done), 0);
        chk(chainEn[ch] == 1'b1, "R6 enable stays high", 32'(chainEn[ch]), 1);
      end
      for (int k = 0; k < 3; k++)
        if (k != ch && (chainClk[k] || !chainRstN[k] || chainEn[k] != enSnap[k])) otherBad = 1'b1;
    end
    chk(rises == len, "R4 clock count", 32'(rises), 32'(len));
    chk(cap == expv, (ch == 2'd0) ? "R9 preamp stream" : "R5 stream order", cap, expv);
    chk(!otherBad, intrude ? "R2 busy command ignored" : "R10 other chains untouched",
        32'(otherBad), 0);
  endtask

  task automatic rejectCmd(input logic [1:0] ch, input logic [15:0] col, input logic [15:0] row,
                           input bit expErr);
    logic [2:0] enSnap = chainEn;
    bit act = 1'b0;
    @(negedge clk);
    cmdValid = 1'b1; cmdChain = ch; cmdColMask = col; cmdRowMask = row;
    @(negedge clk);
    cmdValid = 1'b0;
    chk(maskErr == expErr, "R8 maskErr on refused command", 32'(maskErr), 32'(expErr));
    chk(busy == 1'b0, "R8 R2 no load started", 32'(busy), 0);
    for (int j = 0; j < 40; j++) begin
      @(negedge clk);
      if (chainClk != 3'b0 || chainRstN != 3'b111 || chainEn != enSnap) act = 1'b1;
    end
    chk(!act, "R8 R2 chains untouched", 32'(act), 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk({busy, done, maskErr} == 3'b0, "R1 status after reset", 32'({busy, done, maskErr}), 0);
    chk(chainRstN == 3'b111, "R1 chain resets high", 32'(chainRstN), 32'h7);
    chk({chainClk, chainData, chainEn} == 9'b0, "R1 chain lines low",
        32'({chainClk, chainData, chainEn}), 0);
    // R9 preamp: every single column, row mask ignored
    for (int c = 0; c < 16; c++) runCmd(2'd0, 16'(1 << c), 16'hA5A5, 1'b0);
    runCmd(2'd0, 16'h8001, 16'hFFFF, 1'b0);
    // R8 readout: every col/row position pair on a diagonal sweep
    for (int c = 0; c < 16; c++) runCmd(2'd2, 16'(1 << c), 16'(1 << (15 - c)), 1'b0);
    // R9 injection: top-left pixel and multi-bit masks
    runCmd(2'd1, 16'h8000, 16'h8000, 1'b0);
    runCmd(2'd1, 16'hF0F1, 16'h3C05, 1'b0);
    runCmd(2'd1, 16'hFFFF, 16'hFFFF, 1'b0);
    // R2 command during load ignored
    runCmd(2'd1, 16'h0001, 16'h0001, 1'b1);
    runCmd(2'd2, 16'h0100, 16'h0010, 1'b1);
    // R8 refused readout masks
    rejectCmd(2'd2, 16'h0000, 16'h0001, 1'b1);
    rejectCmd(2'd2, 16'h0003, 16'h0001, 1'b1);
    rejectCmd(2'd2, 16'h0004, 16'h0000, 1'b1);
    rejectCmd(2'd2, 16'h0004, 16'h8080, 1'b1);
    // R8 next accepted command clears the flag (checked at j==0)
    runCmd(2'd0, 16'h0002, 16'h0000, 1'b0);
    // R2 chain code 3 is ignored and raises no error
    rejectCmd(2'd3, 16'h0001, 16'h0001, 1'b0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule